// File: doc/BRIEF.md
# Programmable Segment Address Translator

This block sits in front of the TLB of a 32-bit processor. It classifies every virtual address by segment and decides how the access proceeds. Each segment's behaviour comes from three 32-bit run-time control words, each holding two 16-bit segment configurations. There is no fixed map. A configuration carries a physical base field, a 3-bit access mode and an error-level escape bit.

For each access, the block takes the current privilege (kernel, supervisor or user) and an error-level flag. It produces exactly one of three outcomes:
- an address-error fault;
- a request to look the address up in the TLB;
- a direct (unmapped) physical address, 36 bits wide, built from the segment base and the address offset.

Its logic is combinational. A parameter selects whether the result passes through one output register.

Top module: `seg_xlate`

## Requirements
- R1: Addresses below 0x40000000 take their configuration from bits [31:16] of control word 2, and addresses 0x40000000–0x7FFFFFFF take it from bits [15:0] of control word 2. Both use offset mask 0x3FFFFFFF.
- R2: The upper half of the address space uses offset mask 0x1FFFFFFF in every segment. It selects as follows: 0x80000000–0x9FFFFFFF uses control word 1 bits [31:16]; 0xA0000000–0xBFFFFFFF uses control word 1 bits [15:0]; 0xC0000000–0xDFFFFFFF uses control word 0 bits [31:16]; 0xE0000000 and above uses control word 0 bits [15:0].
- R3: Within a 16-bit configuration, bits [15:9] are the physical base field, bits [6:4] the access mode and bit 3 the error-level escape bit. Bits [8:7] and [2:0] have no effect on any output.
- R4: Privilege code 0 is kernel. In kernel mode, access modes 1, 2 and 3 request a TLB lookup, and modes 0, 4, 5 and 7 are unmapped.
- R5: Privilege code 1 is supervisor. In supervisor mode, modes 0 and 1 fault, modes 2, 3 and 4 request a TLB lookup, and modes 5 and 7 are unmapped.
- R6: Privilege code 2 is user, and code 3 behaves as user. In user mode, modes 0, 1, 2 and 5 fault, modes 3 and 4 request a TLB lookup, and mode 7 is unmapped.
- R7: Access mode 6 faults in every privilege mode, with or without the error level.
- R8: With the error level set and the escape bit 1, every access mode other than 6 is unmapped.
- R9: With the error level set and the escape bit 0, the outcome is the one given by R4–R6 for the current privilege code.
- R10: For an unmapped access, the physical address is formed in two steps. First, the base field is placed at bits [35:29] with all bits under the offset mask cleared. Then it is ORed with the virtual address ANDed with the offset mask. When the outcome is not unmapped, the address output is zero.
- R11: After reset, exactly one of fault_addr, need_tlb and direct_ok is 1.
- R12: With REG_OUT=1 (default), the outputs reflect the inputs present at the previous rising clock edge. They hold their previous value until the next edge, and all outputs are zero while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| vaddr | input | 32 | Virtual address |
| priv_mode | input | 2 | 0 kernel, 1 supervisor, 2 or 3 user |
| err_level | input | 1 | Error-level flag |
| seg_ctl0 | input | 32 | Control word 0: two segment configurations |
| seg_ctl1 | input | 32 | Control word 1: two segment configurations |
| seg_ctl2 | input | 32 | Control word 2: two segment configurations |
| fault_addr | output | 1 | Address-error outcome |
| need_tlb | output | 1 | TLB lookup outcome |
| direct_ok | output | 1 | Unmapped outcome, paddr valid |
| paddr | output | 36 | Physical address for unmapped accesses |

## Verification
Directed vectors visit every access mode under every privilege code. This separates the three outcome tables and shows that code 3 collapses onto user. Each segment boundary is hit with a distinct configuration per control half, so a swapped half or a wrong boundary changes the outcome or the base. Error-level vectors with the escape bit set and then cleared distinguish forced unmapping from privilege-based checking. Vectors with junk in the ignored bits and with all-ones bases expose field misplacement and mask errors. A long run of random addresses and control words, compared each clock against a table-driven model, covers combinations the directed set misses.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      PRIV_KERN = 2'd0,
      PRIV_SUPV = 2'd1,
      PRIV_USER = 2'd2,
      PRIV_ALT  = 2'd3
   } priv_e;

   localparam int CFG_BITS   = 16;
   localparam int BASE_HI    = 15;
   localparam int BASE_LO    = 9;
   localparam int BASE_W     = BASE_HI - BASE_LO + 1;
   localparam int MODE_HI    = 6;
   localparam int MODE_LO    = 4;
   localparam int ESC_BIT    = 3;
   localparam logic [2:0] MODE_RSVD = 3'd6;

   typedef struct packed {
      logic [BASE_W-1:0] base;
      logic [2:0]        mode;
      logic              esc;
   } seg_cfg_t;

endpackage

// File: rtl/seg_cfg_sel.sv
module seg_cfg_sel
   import seg_xlate_pkg::*;
#(
   parameter int VA_W  = 32,
   parameter int NREG  = 3
) (
   input  logic [NREG-1:0][2*CFG_BITS-1:0] ctl,
   input  logic [VA_W-1:0]                 va,
   output seg_cfg_t                        cfg,
   output logic [VA_W-1:0]                 mask
);
   localparam int NSEG  = 2 * NREG;
   localparam int IDX_W = $clog2(NSEG);
   localparam logic [VA_W-1:0] WIDE_MASK   = (VA_W'(1) << (VA_W - 2)) - VA_W'(1);
   localparam logic [VA_W-1:0] NARROW_MASK = (VA_W'(1) << (VA_W - 3)) - VA_W'(1);

   if (NREG != 3) begin : g_bad_nreg
      $error("seg_cfg_sel: layout needs exactly three control words");
   end

   logic [CFG_BITS-1:0] halves [NSEG];

   for (genvar i = 0; i < NREG; i++) begin : g_unpack
      assign halves[2*i]   = ctl[i][CFG_BITS-1:0];
      assign halves[2*i+1] = ctl[i][2*CFG_BITS-1:CFG_BITS];
   end

   logic [IDX_W-1:0]    idx;
   logic [CFG_BITS-1:0] raw;

   always_comb begin
      if (!va[VA_W-1]) begin
         idx  = va[VA_W-2] ? IDX_W'(4) : IDX_W'(5);
         mask = WIDE_MASK;
      end else begin
         idx  = IDX_W'(3) - IDX_W'(va[VA_W-2:VA_W-3]);
         mask = NARROW_MASK;
      end
   end

   assign raw      = halves[idx];
   assign cfg.base = raw[BASE_HI:BASE_LO];
   assign cfg.mode = raw[MODE_HI:MODE_LO];
   assign cfg.esc  = raw[ESC_BIT];

   logic unused_cfg_bits;
   assign unused_cfg_bits = ^{raw[BASE_LO-1:MODE_HI+1], raw[ESC_BIT-1:0]};

endmodule

// File: rtl/seg_mode_dec.sv
module seg_mode_dec
   import seg_xlate_pkg::*;
(
   input  seg_cfg_t   cfg,
   input  logic [1:0] priv,
   input  logic       erl,
   output logic       fault,
   output logic       mapped
);
   priv_e eff;

   always_comb begin
      eff = priv_e'(priv);
      if (eff == PRIV_ALT) eff = PRIV_USER;
   end

   always_comb begin
      fault  = 1'b0;
      mapped = 1'b0;
      if (cfg.mode == MODE_RSVD) begin
         fault = 1'b1;
      end else if (erl && cfg.esc) begin
         mapped = 1'b0;
      end else begin
         unique case (eff)
            PRIV_KERN: begin
               mapped = cfg.mode inside {3'd1, 3'd2, 3'd3};
            end
            PRIV_SUPV: begin
               fault  = cfg.mode inside {3'd0, 3'd1};
               mapped = cfg.mode inside {3'd2, 3'd3, 3'd4};
            end
            default: begin
               fault  = cfg.mode inside {3'd0, 3'd1, 3'd2, 3'd5};
               mapped = cfg.mode inside {3'd3, 3'd4};
            end
         endcase
      end
   end

endmodule

// File: rtl/seg_pa_build.sv
module seg_pa_build
   import seg_xlate_pkg::*;
#(
   parameter int VA_W  = 32,
   parameter int PA_W  = 36,
   parameter int SHIFT = 20
) (
   input  logic [BASE_W-1:0] base,
   input  logic [VA_W-1:0]   va,
   input  logic [VA_W-1:0]   mask,
   input  logic              en,
   output logic [PA_W-1:0]   pa
);
   localparam int BASE_POS = BASE_LO + SHIFT;

   if (BASE_POS + BASE_W != PA_W) begin : g_bad_pa
      $error("seg_pa_build: base field does not fill the top of the physical address");
   end
   if (PA_W < VA_W) begin : g_bad_va
      $error("seg_pa_build: physical address narrower than virtual");
   end

   logic [PA_W-1:0] base_full;
   logic [PA_W-1:0] mask_full;

   assign base_full = {base, {BASE_POS{1'b0}}};
   assign mask_full = {{(PA_W-VA_W){1'b0}}, mask};
   assign pa = en ? ((base_full & ~mask_full) | {{(PA_W-VA_W){1'b0}}, va & mask})
                  : '0;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int PA_W    = 36,
   parameter int SHIFT   = 20,
   parameter bit REG_OUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [VA_W-1:0] vaddr,
   input  logic [1:0]      priv_mode,
   input  logic            err_level,
   input  logic [31:0]     seg_ctl0,
   input  logic [31:0]     seg_ctl1,
   input  logic [31:0]     seg_ctl2,
   output logic            fault_addr,
   output logic            need_tlb,
   output logic            direct_ok,
   output logic [PA_W-1:0] paddr
);
   localparam int NREG = 3;

   if (VA_W != 32) begin : g_bad_va
      $error("seg_xlate: segment layout assumes a 32-bit virtual address");
   end

   logic [NREG-1:0][2*CFG_BITS-1:0] ctl;
   seg_cfg_t        sel_cfg;
   logic [VA_W-1:0] sel_mask;
   logic            dec_fault;
   logic            dec_mapped;
   logic            dec_direct;
   logic [PA_W-1:0] pa_c;

   assign ctl = {seg_ctl2, seg_ctl1, seg_ctl0};

   seg_cfg_sel #(.VA_W(VA_W), .NREG(NREG)) u_sel (
      .ctl  (ctl),
      .va   (vaddr),
      .cfg  (sel_cfg),
      .mask (sel_mask)
   );

   seg_mode_dec u_dec (
      .cfg    (sel_cfg),
      .priv   (priv_mode),
      .erl    (err_level),
      .fault  (dec_fault),
      .mapped (dec_mapped)
   );

   assign dec_direct = !dec_fault && !dec_mapped;

   seg_pa_build #(.VA_W(VA_W), .PA_W(PA_W), .SHIFT(SHIFT)) u_pa (
      .base (sel_cfg.base),
      .va   (vaddr),
      .mask (sel_mask),
      .en   (dec_direct),
      .pa   (pa_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fault_addr <= 1'b0;
            need_tlb   <= 1'b0;
            direct_ok  <= 1'b0;
            paddr      <= '0;
         end else begin
            fault_addr <= dec_fault;
            need_tlb   <= dec_mapped;
            direct_ok  <= dec_direct;
            paddr      <= pa_c;
         end
      end
   end else begin : g_comb
      assign fault_addr = dec_fault;
      assign need_tlb   = dec_mapped;
      assign direct_ok  = dec_direct;
      assign paddr      = pa_c;
   end

   // R11
   outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $onehot({fault_addr, need_tlb, direct_ok}));

   // R7
   rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_cfg.mode == MODE_RSVD) |-> dec_fault);

   // R8
   erl_escape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_level && sel_cfg.esc && sel_cfg.mode != MODE_RSVD) |-> (!dec_fault && !dec_mapped));

   // R4
   kern_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_mode == 2'd0 && sel_cfg.mode != MODE_RSVD) |-> !dec_fault);

   // R10
   pa_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_direct |-> ((pa_c[VA_W-1:0] & sel_mask) == (vaddr & sel_mask)));

   // R5
   supv_low_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_mode == 2'd1 && sel_cfg.mode inside {3'd0, 3'd1} && !(err_level && sel_cfg.esc))
         |-> dec_fault);

endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] vaddr;
   logic [1:0]  priv_mode;
   logic        err_level;
   logic [31:0] seg_ctl0, seg_ctl1, seg_ctl2;
   logic        fault_addr, need_tlb, direct_ok;
   logic [35:0] paddr;

   always #2 clk = ~clk;

   seg_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .priv_mode(priv_mode),
      .err_level(err_level), .seg_ctl0(seg_ctl0), .seg_ctl1(seg_ctl1),
      .seg_ctl2(seg_ctl2), .fault_addr(fault_addr), .need_tlb(need_tlb),
      .direct_ok(direct_ok), .paddr(paddr)
   );

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   // highest privilege level (0 kern,1 supv,2 user) allowed per mode; -1 never
   int       allow_lim [8] = '{0, 0, 1, 2, 2, 1, -1, 2};
   // bit n set: level n is sent to TLB
   bit [2:0] map_lvls  [8] = '{3'b000, 3'b001, 3'b011, 3'b111, 3'b110, 3'b000, 3'b000, 3'b000};

   logic        pf, pt, pu;
   logic [35:0] pa_prev;

   function automatic logic [15:0] mkcfg(input int base, input int mode, input bit esc, input int junk);
      logic [15:0] c;
      c = 16'(base * 512 + ((junk / 8) % 4) * 128 + mode * 16 + (esc ? 8 : 0) + junk % 8);
      return c;
   endfunction

   function automatic void model(input logic [31:0] v, input logic [1:0] p, input logic e,
                                 input logic [31:0] c0, input logic [31:0] c1, input logic [31:0] c2,
                                 output logic f, output logic t, output logic u,
                                 output logic [35:0] a, output string tg);
      logic [15:0] cf;
      logic [31:0] msk;
      int          md, lvl;
      logic [35:0] bse;
      if (v < 32'h4000_0000)      begin cf = c2[31:16]; msk = 32'h3FFF_FFFF; end
      else if (v < 32'h8000_0000) begin cf = c2[15:0];  msk = 32'h3FFF_FFFF; end
      else if (v < 32'hA000_0000) begin cf = c1[31:16]; msk = 32'h1FFF_FFFF; end
      else if (v < 32'hC000_0000) begin cf = c1[15:0];  msk = 32'h1FFF_FFFF; end
      else if (v < 32'hE000_0000) begin cf = c0[31:16]; msk = 32'h1FFF_FFFF; end
      else                        begin cf = c0[15:0];  msk = 32'h1FFF_FFFF; end
      md  = int'(cf[6:4]);
      lvl = (p == 2'd0) ? 0 : (p == 2'd1) ? 1 : 2;
      f = 1'b0; t = 1'b0; u = 1'b0; a = '0;
      if (md == 6) begin f = 1'b1; tg = "R7"; end
      else if (e && cf[3]) begin u = 1'b1; tg = "R8"; end
      else begin
         if (e) tg = "R9";
         else tg = (lvl == 0) ? "R4" : (lvl == 1) ? "R5" : "R6";
         if (lvl > allow_lim[md]) f = 1'b1;
         else if (map_lvls[md][lvl]) t = 1'b1;
         else u = 1'b1;
      end
      if (u) begin
         bse = 36'(cf[15:9]) * 36'h2000_0000;
         a = (bse & ~{4'h0, msk}) | {4'h0, v & msk};
      end
   endfunction

   task automatic check_out(input string tg, input logic ef, input logic et, input logic eu,
                            input logic [35:0] ea);
      checks++;
      if (fault_addr !== ef || need_tlb !== et || direct_ok !== eu || paddr !== ea) begin
         fails++;
         $display("FAIL %s: got f=%b t=%b u=%b pa=%h expected f=%b t=%b u=%b pa=%h",
                  tg, fault_addr, need_tlb, direct_ok, paddr, ef, et, eu, ea);
      end
   endtask

   // one vector per clock: drive at negedge, model at posedge, compare at next negedge
   task automatic vec(input string dtag, input logic [31:0] v, input logic [1:0] p, input logic e,
                      input logic [31:0] c0, input logic [31:0] c1, input logic [31:0] c2);
      logic ef, et, eu;
      logic [35:0] ea;
      string mt;
      vaddr = v; priv_mode = p; err_level = e;
      seg_ctl0 = c0; seg_ctl1 = c1; seg_ctl2 = c2;
      #1;
      // R12: registered outputs keep the previous result until the edge
      check_out("R12 hold", pf, pt, pu, pa_prev);
      @(posedge clk);
      model(v, p, e, c0, c1, c2, ef, et, eu, ea, mt);
      @(negedge clk);
      check_out({dtag, "/", mt}, ef, et, eu, ea);
      checks++;
      if ($countones({fault_addr, need_tlb, direct_ok}) != 1) begin
         fails++;
         $display("FAIL R11: outcome flags %b expected exactly one set",
                  {fault_addr, need_tlb, direct_ok});
      end
      pf = ef; pt = et; pu = eu; pa_prev = ea;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] k0, k1, k2;
      rst_n = 1'b0;
      vaddr = 32'h8000_1234; priv_mode = 2'd0; err_level = 1'b0;
      seg_ctl0 = 32'h0; seg_ctl1 = {mkcfg(127, 7, 0, 0), 16'h0}; seg_ctl2 = 32'h0;
      repeat (3) @(negedge clk);
      // R12: outputs are zero during reset
      check_out("R12 reset", 1'b0, 1'b0, 1'b0, 36'h0);
      rst_n = 1'b1;
      pf = 1'b0; pt = 1'b0; pu = 1'b0; pa_prev = '0;

      // R1: the two 1 GB user-region halves of control word 2
      k2 = {mkcfg(5, 7, 0, 0), mkcfg(9, 1, 0, 0)};
      vec("R1", 32'h1234_5678, 2'd0, 1'b0, 32'h0, 32'h0, k2);
      vec("R1", 32'h3FFF_FFFF, 2'd0, 1'b0, 32'h0, 32'h0, k2);
      vec("R1", 32'h4000_0000, 2'd0, 1'b0, 32'h0, 32'h0, k2);
      vec("R1", 32'h7FFF_FFFF, 2'd2, 1'b0, 32'h0, 32'h0, k2);

      // R2: four 512 MB segments, each with a distinct mode
      k0 = {mkcfg(3, 2, 0, 0), mkcfg(4, 0, 0, 0)};
      k1 = {mkcfg(1, 7, 0, 0), mkcfg(2, 5, 0, 0)};
      for (int s = 0; s < 2; s++) begin
         vec("R2", 32'h8000_0000, 2'd1, 1'b0, k0, k1, 32'h0);
         vec("R2", 32'h9FFF_FFF0, 2'd1, 1'b0, k0, k1, 32'h0);
         vec("R2", 32'hA000_0004, 2'd1, 1'b0, k0, k1, 32'h0);
         vec("R2", 32'hC000_0008, 2'd1, 1'b0, k0, k1, 32'h0);
         vec("R2", 32'hDFFF_FFFF, 2'd0, 1'b0, k0, k1, 32'h0);
         vec("R2", 32'hE000_0000, 2'd0, 1'b0, k0, k1, 32'h0);
         vec("R2", 32'hFFFF_FFFF, 2'd2, 1'b0, k0, k1, 32'h0);
      end

      // R3: ignored configuration bits carry junk
      for (int j = 0; j < 32; j += 7) begin
         k1 = {mkcfg(85, 7, 0, j), mkcfg(42, 4, 0, 31 - j)};
         vec("R3", 32'h8765_4321, 2'd0, 1'b0, 32'h0, k1, 32'h0);
         vec("R3", 32'hA765_4321, 2'd0, 1'b0, 32'h0, k1, 32'h0);
         vec("R3", 32'hA765_4321, 2'd2, 1'b0, 32'h0, k1, 32'h0);
      end

      // R4 R5 R6: every mode under every privilege code
      for (int p = 0; p < 4; p++) begin
         for (int m = 0; m < 8; m++) begin
            k1 = {mkcfg(17, m, 0, 0), 16'h0};
            vec(p == 0 ? "R4" : p == 1 ? "R5" : "R6", 32'h8123_4567, 2'(p), 1'b0, 32'h0, k1, 32'h0);
         end
      end

      // R7 R8 R9: error level with escape bit set and clear
      for (int p = 0; p < 4; p++) begin
         for (int m = 0; m < 8; m++) begin
            k0 = {16'h0, mkcfg(33, m, 1, 0)};
            vec(m == 6 ? "R7" : "R8", 32'hF000_0100, 2'(p), 1'b1, k0, 32'h0, 32'h0);
            k0 = {16'h0, mkcfg(33, m, 0, 0)};
            vec(m == 6 ? "R7" : "R9", 32'hF000_0100, 2'(p), 1'b1, k0, 32'h0, 32'h0);
         end
      end

      // R10: base field extremes against both offset masks
      vec("R10", 32'h3ABC_DEF0, 2'd0, 1'b0, 32'h0, 32'h0, {mkcfg(127, 7, 0, 0), 16'h0});
      vec("R10", 32'h5ABC_DEF0, 2'd0, 1'b0, 32'h0, 32'h0, {16'h0, mkcfg(126, 5, 0, 0)});
      vec("R10", 32'hBFFF_FFFF, 2'd0, 1'b0, 32'h0, {16'h0, mkcfg(127, 4, 0, 0)}, 32'h0);
      vec("R10", 32'hC000_0000, 2'd1, 1'b0, {mkcfg(64, 5, 0, 0), 16'h0}, 32'h0, 32'h0);
      vec("R10", 32'hC000_0000, 2'd1, 1'b0, {mkcfg(64, 4, 0, 0), 16'h0}, 32'h0, 32'h0);

      // random sweep covering R1..R11 together
      for (int n = 0; n < 4000; n++) begin
         vec("rand", $urandom, 2'($urandom), 1'($urandom), $urandom, $urandom, $urandom);
      end

      // R12: reset clears outputs again
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_out("R12 reset", 1'b0, 1'b0, 1'b0, 36'h0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule